// File: doc/BRIEF.md
# Cross-Domain Run and Soft-Reset Control Register

This block sits on a register bus in one clock domain and controls a peripheral clocked in another. Software writes a run bit, a soft-reset bit and a configuration byte through a plain write port and reads them back through a combinational read port. A second register holds debug settings that a soft reset leaves alone. A third, read-only register reports two busy flags.

The run bit and the soft-reset request each cross to the peripheral clock through a toggle handshake. A request flag flips in the bus domain, passes through a two-flop synchronizer, and raises a single-cycle strobe in the peripheral domain. The strobe's level returns through a second synchronizer as the acknowledge. A busy flag stays high for each transfer until that acknowledge arrives. The configuration byte is frozen while the stored run bit is set, so the peripheral may sample it without a synchronizer.

Register map: address 0 is control (bit 0 soft reset, bit 1 run, bits 15:8 configuration). Address 1 is debug (bits 7:0). Address 2 is status (bit 0 reset busy, bit 1 run busy). Unmapped addresses read as zero.

Top module: `sync_ctrl_reg`

## Requirements
- R1: A control write with bit 0 clear, accepted while no transfer is busy, shows its bit 1 in the run field on the next read, and `busy_run` (status bit 1) is high from the next cycle.
- R2: When `busy_run` falls, `p_run` already equals the last run value accepted.
- R3: A control write made while `busy_run` is high does not change the stored run bit or `p_run`.
- R4: A control write with bit 0 clear starts no reset: `busy_reset` stays low and the written configuration is kept.
- R5: A soft reset returns the run bit and configuration to zero, keeps the debug register, and leaves `p_run` low once complete.
- R6: A control write with bit 0 set discards its run and configuration fields; the next control read is 0x00000001.
- R7: The soft-reset bit (control bit 0) and `busy_reset` rise and fall together, and each soft reset gives exactly one `p_reset` pulse of one peripheral cycle.
- R8: While `busy_reset` is high, writes to the debug and control registers are ignored.
- R9: The configuration field is written only when the stored run bit is 0; otherwise it keeps its value.
- R10: After hardware reset every register reads 0 and all outputs are low.
- R11: A soft reset requested while a run transfer is still busy is held back until that transfer ends, and afterwards `p_run` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational |
| busy_run | output | 1 | Run transfer in flight |
| busy_reset | output | 1 | Soft reset in progress |
| cfg_out | output | CFG_W | Configuration byte, static while running |
| dbg_out | output | DBG_W | Debug register contents |
| pclk | input | 1 | Peripheral clock |
| prst_n | input | 1 | Peripheral-domain reset, active low |
| p_run | output | 1 | Run state in the peripheral domain |
| p_reset | output | 1 | One-cycle soft-reset strobe in the peripheral domain |

## Verification
The bench targets a run write that arrives while the previous one is still in flight. A design that lets it through would flip `p_run` mid-handshake or leave it mismatched when busy falls. It also sends a soft reset that carries run and configuration bits, followed by writes during the reset. A wrong design would keep those fields, lose debug contents, or accept the late writes. A soft reset issued immediately after a run-enable write checks that the reset waits for the run transfer. If it did not wait, the late run strobe could leave the peripheral running after the reset.

// File: rtl/sync_ctrl_pkg.sv
package sync_ctrl_pkg;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 32;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_DBG  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam int B_SRST  = 0;
  localparam int B_RUN   = 1;
  localparam int CFG_LSB = 8;
  localparam int CH_RUN  = 0;
  localparam int CH_RST  = 1;
  localparam int N_CH    = 2;
endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tgl_xfer.sv
module tgl_xfer #(
  parameter int STAGES = 2
) (
  input  logic a_clk,
  input  logic a_rst_n,
  input  logic a_launch,
  output logic a_busy,
  input  logic b_clk,
  input  logic b_rst_n,
  output logic b_strobe
);
  logic req_a, req_b, seen_b, ack_a;

  // source side: each launch flips the request level
  always_ff @(posedge a_clk or negedge a_rst_n) begin
    if (!a_rst_n)      req_a <= 1'b0;
    else if (a_launch) req_a <= ~req_a;
  end

  sync_bits #(.STAGES(STAGES)) u_fwd (
    .clk(b_clk), .rst_n(b_rst_n), .d(req_a), .q(req_b)
  );

  // destination side: level change becomes a one-cycle strobe
  always_ff @(posedge b_clk or negedge b_rst_n) begin
    if (!b_rst_n) seen_b <= 1'b0;
    else          seen_b <= req_b;
  end
  assign b_strobe = req_b ^ seen_b;

  // acknowledge returns the level already taken up
  sync_bits #(.STAGES(STAGES)) u_back (
    .clk(a_clk), .rst_n(a_rst_n), .d(seen_b), .q(ack_a)
  );
  assign a_busy = req_a ^ ack_a;
endmodule

// File: rtl/sync_ctrl_reg.sv
module sync_ctrl_reg
  import sync_ctrl_pkg::*;
#(
  parameter int CFG_W  = 8,
  parameter int DBG_W  = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy_run,
  output logic              busy_reset,
  output logic [CFG_W-1:0]  cfg_out,
  output logic [DBG_W-1:0]  dbg_out,
  input  logic              pclk,
  input  logic              prst_n,
  output logic              p_run,
  output logic              p_reset
);
  localparam int CFG_MSB = CFG_LSB + CFG_W - 1;

  logic             run_q, run_tx, rst_act, rst_sent;
  logic [CFG_W-1:0] cfg_q;
  logic [DBG_W-1:0] dbg_q;
  logic [N_CH-1:0]  launch, ch_busy, ch_strobe;

  logic wr_ctrl, srst_req, run_wr, dbg_wr;
  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL) && !rst_act;
  assign srst_req = wr_ctrl && wr_data[B_SRST];
  assign run_wr   = wr_ctrl && !wr_data[B_SRST] && !ch_busy[CH_RUN];
  assign dbg_wr   = wr_en && (wr_addr == A_DBG) && !rst_act;

  assign launch[CH_RUN] = run_wr;
  assign launch[CH_RST] = rst_act && !rst_sent && !ch_busy[CH_RUN];

  generate
    for (genvar gi = 0; gi < N_CH; gi++) begin : g_ch
      tgl_xfer #(.STAGES(STAGES)) u_xfer (
        .a_clk(clk), .a_rst_n(rst_n), .a_launch(launch[gi]), .a_busy(ch_busy[gi]),
        .b_clk(pclk), .b_rst_n(prst_n), .b_strobe(ch_strobe[gi])
      );
    end
  endgenerate

  // bus-domain register state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      run_tx   <= 1'b0;
      cfg_q    <= '0;
      rst_act  <= 1'b0;
      rst_sent <= 1'b0;
    end else if (srst_req) begin
      run_q    <= 1'b0;
      cfg_q    <= '0;
      rst_act  <= 1'b1;
      rst_sent <= 1'b0;
    end else begin
      if (run_wr) begin
        run_q  <= wr_data[B_RUN];
        run_tx <= wr_data[B_RUN];
      end
      if (wr_ctrl && !run_q) cfg_q <= wr_data[CFG_MSB:CFG_LSB];
      if (launch[CH_RST]) rst_sent <= 1'b1;
      if (rst_sent && !ch_busy[CH_RST]) begin
        rst_act  <= 1'b0;
        rst_sent <= 1'b0;
      end
    end
  end

  // debug register survives soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dbg_q <= '0;
    else if (dbg_wr) dbg_q <= wr_data[DBG_W-1:0];
  end

  // peripheral-domain outputs
  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      p_run   <= 1'b0;
      p_reset <= 1'b0;
    end else begin
      p_reset <= ch_strobe[CH_RST];
      if (ch_strobe[CH_RST])      p_run <= 1'b0;
      else if (ch_strobe[CH_RUN]) p_run <= run_tx;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[B_SRST]          = rst_act;
        rd_data[B_RUN]           = run_q;
        rd_data[CFG_MSB:CFG_LSB] = cfg_q;
      end
      A_DBG:   rd_data[DBG_W-1:0] = dbg_q;
      A_STAT: begin
        rd_data[0] = rst_act;
        rd_data[1] = ch_busy[CH_RUN];
      end
      default: rd_data = '0;
    endcase
  end

  assign busy_run   = ch_busy[CH_RUN];
  assign busy_reset = rst_act;
  assign cfg_out    = cfg_q;
  assign dbg_out    = dbg_q;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[DATA_W-1:CFG_MSB+1], wr_data[CFG_LSB-1:B_RUN+1]};
endmodule

// File: rtl/sync_ctrl_chk.sv
module sync_ctrl_chk
  import sync_ctrl_pkg::*;
#(
  parameter int CFG_W = 8,
  parameter int DBG_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pclk,
  input logic              prst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              run_q,
  input logic [CFG_W-1:0]  cfg_q,
  input logic [DBG_W-1:0]  dbg_q,
  input logic              busy_run,
  input logic              busy_reset,
  input logic              p_run,
  input logic              p_reset
);
  logic ctrl_wr, srst_wr;
  assign ctrl_wr = wr_en && (wr_addr == A_CTRL) && !busy_reset;
  assign srst_wr = ctrl_wr && wr_data[B_SRST];

  // R1
  a_r1_run_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wr_data[B_SRST] && !busy_run) |=> (busy_run && run_q == $past(wr_data[B_RUN])));

  // R3
  a_r3_run_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_run && !srst_wr) |=> $stable(run_q));

  // R9
  a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !srst_wr) |=> $stable(cfg_q));

  // R5
  a_r5_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_reset) |-> (!run_q && cfg_q == '0));

  // R8
  a_r8_dbg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_reset |=> $stable(dbg_q));

  // R11
  a_r11_quiet_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_reset) |-> !busy_run);

  // R7
  a_r7_single_pulse: assert property (@(posedge pclk) disable iff (!prst_n)
    p_reset |=> !p_reset);

  // R5
  a_r5_p_off: assert property (@(posedge pclk) disable iff (!prst_n)
    p_reset |-> !p_run);
endmodule

bind sync_ctrl_reg sync_ctrl_chk #(.CFG_W(CFG_W), .DBG_W(DBG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pclk(pclk), .prst_n(prst_n),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .run_q(run_q), .cfg_q(cfg_q), .dbg_q(dbg_q),
  .busy_run(busy_run), .busy_reset(busy_reset),
  .p_run(p_run), .p_reset(p_reset)
);

// File: tb/test_sync_ctrl_reg.sv
`timescale 1ns/1ps
module test_sync_ctrl_reg;
  logic        clk = 1'b0, pclk = 1'b0, rst_n = 1'b0, prst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        busy_run, busy_reset, p_run, p_reset;
  logic [7:0]  cfg_out, dbg_out;

  int n_run = 0, n_fail = 0, pulses = 0;
  bit finished = 0;

  always #10 clk = ~clk;
  always #7  pclk = ~pclk;

  sync_ctrl_reg i_sync_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy_run(busy_run), .busy_reset(busy_reset),
    .cfg_out(cfg_out), .dbg_out(dbg_out), .pclk(pclk), .prst_n(prst_n),
    .p_run(p_run), .p_reset(p_reset)
  );

  always @(negedge pclk) if (p_reset) pulses++;

  localparam int NV = 8;
  localparam logic [1:0]  V_WA  [NV] = '{2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2};
  localparam logic [31:0] V_WD  [NV] = '{32'h0000AB00, 32'h0000005A, 32'h0000AB02, 32'h0000CD02,
                                         32'h0000CD00, 32'h0000CD00, 32'h00003400, 32'h0};
  localparam logic [1:0]  V_RA  [NV] = '{2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2};
  localparam logic [31:0] V_EXP [NV] = '{32'h0000AB00, 32'h0000005A, 32'h0000AB02, 32'h0000AB02,
                                         32'h0000AB00, 32'h0000CD00, 32'h00003400, 32'h0};
  localparam logic        V_RUN [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  // tags: R9 cfg write, R8 debug write, R1 run on, R9 locked, R9 locked, R9 open, R4 no reset, R2 idle
  localparam int          V_REQ [NV] = '{9, 8, 1, 9, 9, 9, 4, 2};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic wait_idle(input string tag);
    int k;
    k = 0;
    while ((busy_run || busy_reset) && k < 100) begin
      @(negedge clk);
      k++;
    end
    check({tag, " idle"}, {31'd0, (busy_run || busy_reset)}, 32'd0);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; prst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check_rd("R10 ctrl", 2'd0, 32'h0);
    check_rd("R10 dbg", 2'd1, 32'h0);
    check_rd("R10 stat", 2'd2, 32'h0);
    check("R10 outputs", {28'd0, busy_run, busy_reset, p_run, p_reset}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", V_REQ[i], i);
      write(V_WA[i], V_WD[i]);
      wait_idle(tag);
      check_rd(tag, V_RA[i], V_EXP[i]);
      check({tag, " p_run"}, {31'd0, p_run}, {31'd0, V_RUN[i]});   // R2 value taken up
    end

    // R1 immediate readback and busy, then R3 write during busy
    write(2'd0, 32'h00003402);
    check_rd("R1 readback", 2'd0, 32'h00003402);
    check("R1 busy_run", {31'd0, busy_run}, 32'd1);
    write(2'd0, 32'h00003400);
    check_rd("R3 run kept", 2'd0, 32'h00003402);
    wait_idle("R2");
    check("R2 p_run on", {31'd0, p_run}, 32'd1);
    check("R3 p_run kept", {31'd0, p_run}, 32'd1);

    // R6 R7 R8 R5 soft reset with extra fields, writes during reset
    write(2'd0, 32'h0000FF03);
    check_rd("R6 fields discarded", 2'd0, 32'h00000001);
    check("R7 busy with bit", {31'd0, busy_reset}, 32'd1);
    write(2'd1, 32'h00000011);
    write(2'd0, 32'h00000002);
    wait_idle("R7");
    check_rd("R7 bit cleared", 2'd0, 32'h0);
    check_rd("R8 dbg kept", 2'd1, 32'h0000005A);
    check("R5 p_run off", {31'd0, p_run}, 32'd0);
    check("R7 one pulse", pulses, 32'd1);
    check_rd("R5 stat clear", 2'd2, 32'h0);

    // R11 soft reset right behind a run transfer
    write(2'd0, 32'h00000002);
    write(2'd0, 32'h00000001);
    check("R11 reset busy", {31'd0, busy_reset}, 32'd1);
    wait_idle("R11");
    check("R11 p_run off", {31'd0, p_run}, 32'd0);
    check_rd("R11 ctrl", 2'd0, 32'h0);
    check("R11 pulse count", pulses, 32'd2);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule